// File: doc/BRIEF.md
# DMA Address Register Sequencer

This block is the address register for one DMA channel. It holds the 32-bit address put on the bus for each read cycle of the channel. After each operand transfer it can step forward by the operand size, which is 1, 2 or 4 bytes, or it can keep its value. The sum is unsigned and wraps past the top of the address space. If a bus error ends a transfer, the register steps forward exactly as it would have on a normal completion. A read of the register therefore always shows the next address to be used.

A start request is checked before the transfer is allowed. A word or long-word operand at an odd address raises a sticky configuration-error flag and blocks the transfer. The unused size code raises the same flag. While the flag is set, every start request is refused. Software clears the flag by writing a one. Software reads and writes of the register, and the flag clear, take effect only while the module-stop input is low.

Top module: `dma_addr_seq`

## Requirements
- R1: Reset clears `cfg_err` and `xfer_ok` to 0 and leaves the address register at the value it held before reset.
- R2: A start request that is accepted (flag clear, no transfer in progress, alignment valid) sets `xfer_ok` to 1 in the next cycle. `bus_addr` equals the register value while `xfer_ok` is 1.
- R3: With `incr_en` = 1, the end of a transfer advances the register by the operand size latched at start. `op_size` is encoded 00 = byte (+1), 01 = word (+2), 10 = long word (+4).
- R4: With `incr_en` = 0, the end of a transfer leaves the register unchanged.
- R5: The increment is unsigned modulo 2^32. For example, 0xFFFFFFFF + 1 = 0x00000000 and 0xFFFFFFFC + 4 = 0x00000000.
- R6: A start request with a word or long-word size and address bit 0 = 1, or with size code 11, sets `cfg_err` in the next cycle and leaves `xfer_ok` at 0.
- R7: `cfg_err` stays set, and start requests are refused, until `err_clr` is pulsed while `mod_stop` = 0.
- R8: A `bus_err` pulse that ends a transfer leaves the register at the same next address that `xfer_done` would have produced, and drops `xfer_ok`.
- R9: While `mod_stop` = 1, `reg_rdata` reads 0 and both `reg_wr` and `err_clr` have no effect.
- R10: A software write in the same cycle as the end of a transfer loads the written value; the increment is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the control state only |
| mod_stop | input | 1 | Module-stop bit; blocks software access |
| reg_wr | input | 1 | Software write strobe for the address register |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Software read data: next address, 0 while stopped |
| err_clr | input | 1 | Write-one-to-clear for the configuration-error flag |
| incr_en | input | 1 | 1 = advance after each operand, 0 = hold |
| op_size | input | 2 | Operand size: 00 byte, 01 word, 10 long word, 11 invalid |
| start_req | input | 1 | Request to begin an operand transfer |
| xfer_done | input | 1 | Operand transfer completed |
| bus_err | input | 1 | Operand transfer ended by a bus error |
| bus_addr | output | 32 | Address driven for the read cycle |
| xfer_ok | output | 1 | Transfer allowed and in progress |
| cfg_err | output | 1 | Sticky configuration-error flag |

## Verification
The assertions check the following on every cycle:
- a rejected start always sets the flag and never raises `xfer_ok`;
- the flag only falls through a permitted clear;
- each completion advances the register by the latched step, or holds it when incrementing is off;
- a permitted write lands exactly, and a write made while stopped is lost.

Some behaviour only the bench's scenarios can show: that the register survives reset, that a bus error and a normal completion leave the same value, that the address wraps at the top of the space, and the full sweep of size codes against address low bits and increment modes.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_BAD  = 2'b11
    } opsz_e;

    localparam int STEP_W = 3;

    // Byte step for an operand size code
    function automatic logic [STEP_W-1:0] step_of(opsz_e sz);
        case (sz)
            SZ_BYTE: step_of = 3'd1;
            SZ_WORD: step_of = 3'd2;
            SZ_LONG: step_of = 3'd4;
            default: step_of = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dma_align_chk.sv
module dma_align_chk
    import dma_seq_pkg::*;
(
    input  opsz_e size_i,
    input  logic  lsb_i,
    output logic  bad_o
);
    // Multi-byte operands need an even address; the spare code is never valid
    always_comb begin
        case (size_i)
            SZ_BYTE:         bad_o = 1'b0;
            SZ_WORD, SZ_LONG: bad_o = lsb_i;
            default:         bad_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  opsz_e         size_i,
    output logic [AW-1:0] addr_o
);
    localparam int PAD = AW - STEP_W;

    logic [STEP_W-1:0] step;

    always_comb begin
        step   = step_of(size_i);
        // Unsigned sum truncated to AW bits: wraps at the top
        addr_o = addr_i + {{PAD{1'b0}}, step};
    end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mod_stop,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          err_clr,
    input  logic          incr_en,
    input  logic [1:0]    op_size,
    input  logic          start_req,
    input  logic          xfer_done,
    input  logic          bus_err,
    output logic [AW-1:0] bus_addr,
    output logic          xfer_ok,
    output logic          cfg_err
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          busy;
        logic          err;
        opsz_e         sz;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic          sw_ok;
    logic          start_bad;
    logic          xfer_end;
    logic [AW-1:0] addr_next;
    opsz_e         req_sz;

    assign req_sz = opsz_e'(op_size);

    dma_align_chk u_align (
        .size_i (req_sz),
        .lsb_i  (st_q.addr[0]),
        .bad_o  (start_bad)
    );

    dma_addr_step #(.AW(AW)) u_step (
        .addr_i (st_q.addr),
        .size_i (st_q.sz),
        .addr_o (addr_next)
    );

    always_comb begin
        st_d     = st_q;
        sw_ok    = !mod_stop;
        xfer_end = st_q.busy && (xfer_done || bus_err);

        // A completion and an error-terminated transfer both move to the next address
        if (xfer_end) begin
            st_d.busy = 1'b0;
            if (incr_en) begin
                st_d.addr = addr_next;
            end
        end

        if (sw_ok && err_clr) begin
            st_d.err = 1'b0;
        end

        if (start_req && !st_q.busy && !st_q.err) begin
            if (start_bad) begin
                st_d.err = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                st_d.sz   = req_sz;
            end
        end

        // A software write overrides the increment
        if (sw_ok && reg_wr) begin
            st_d.addr = reg_wdata;
        end
    end

    // Address is deliberately outside reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.err  <= 1'b0;
            st_q.sz   <= SZ_BYTE;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_addr  = st_q.addr;
    assign xfer_ok   = st_q.busy;
    assign cfg_err   = st_q.err;
    assign reg_rdata = sw_ok ? st_q.addr : '0;

    // R6: a misaligned or invalid start raises the flag, never the grant
    a_r6_bad_start_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !xfer_ok && !cfg_err && start_bad) |=> (cfg_err && !xfer_ok));

    // R7: the flag only drops through a permitted clear
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !(err_clr && !mod_stop)) |=> cfg_err);

    // R7: no grant is issued while the flag was set
    a_r7_no_grant_in_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_ok) |-> !$past(cfg_err));

    // R3: completion with incrementing steps by the latched operand size
    a_r3_step_size: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ok && (xfer_done || bus_err) && incr_en && !(reg_wr && !mod_stop))
        |=> (bus_addr == $past(bus_addr) + AW'(step_of($past(st_q.sz)))));

    // R4: completion without incrementing holds the address
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ok && (xfer_done || bus_err) && !incr_en && !(reg_wr && !mod_stop))
        |=> $stable(bus_addr));

    // R10: a permitted write always lands
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !mod_stop) |=> (bus_addr == $past(reg_wdata)));

    // R9: a write while stopped leaves the address alone when nothing else moves it
    a_r9_stop_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_stop && reg_wr && !(xfer_ok && (xfer_done || bus_err)))
        |=> $stable(bus_addr));

endmodule

// File: tb/tb_dma_addr_seq.sv
module tb_dma_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_stop = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        err_clr = 1'b0;
    logic        incr_en = 1'b0;
    logic [1:0]  op_size = 2'b00;
    logic        start_req = 1'b0;
    logic        xfer_done = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_addr;
    logic        xfer_ok;
    logic        cfg_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_addr_seq dut (
        .clk(clk), .rst_n(rst_n), .mod_stop(mod_stop),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_clr(err_clr), .incr_en(incr_en), .op_size(op_size),
        .start_req(start_req), .xfer_done(xfer_done), .bus_err(bus_err),
        .bus_addr(bus_addr), .xfer_ok(xfer_ok), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_addr(input logic [31:0] a);
        reg_wr = 1'b1; reg_wdata = a; cyc(); reg_wr = 1'b0;
    endtask

    function automatic logic [31:0] stepv(input logic [1:0] sz);
        return (sz == 2'b00) ? 32'd1 : (sz == 2'b01) ? 32'd2 : 32'd4;
    endfunction

    task automatic do_xfer(input logic [31:0] a, input logic [1:0] sz,
                           input logic inc, input logic be);
        logic bad;
        logic [31:0] exp;
        bad = (sz == 2'b11) || (sz != 2'b00 && a[0]);
        wr_addr(a);
        op_size = sz; incr_en = inc; start_req = 1'b1; cyc(); start_req = 1'b0;
        if (bad) begin
            chk("R6 cfg_err", {31'd0, cfg_err}, 32'd1);
            chk("R6 xfer_ok", {31'd0, xfer_ok}, 32'd0);
            start_req = 1'b1; op_size = 2'b00; cyc(); start_req = 1'b0;
            chk("R7 start refused", {31'd0, xfer_ok}, 32'd0);
            err_clr = 1'b1; cyc(); err_clr = 1'b0;
            chk("R7 cleared", {31'd0, cfg_err}, 32'd0);
        end else begin
            chk("R2 grant", {31'd0, xfer_ok}, 32'd1);
            chk("R2 bus_addr", bus_addr, a);
            if (be) bus_err = 1'b1; else xfer_done = 1'b1;
            cyc(); bus_err = 1'b0; xfer_done = 1'b0;
            exp = inc ? a + stepv(sz) : a;
            chk(be ? "R8 next after bus error" : (inc ? "R3 step" : "R4 hold"), reg_rdata, exp);
            chk("R8 grant dropped", {31'd0, xfer_ok}, 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1 cfg_err after reset", {31'd0, cfg_err}, 32'd0);
        chk("R1 xfer_ok after reset", {31'd0, xfer_ok}, 32'd0);

        // R1: register survives reset, including reset in mid-transfer
        wr_addr(32'h1234_5678);
        op_size = 2'b00; start_req = 1'b1; cyc(); start_req = 1'b0;
        rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
        chk("R1 address kept", reg_rdata, 32'h1234_5678);
        chk("R1 grant cleared", {31'd0, xfer_ok}, 32'd0);

        // Sweep: size code x low address bits x increment mode x ending
        for (int sz = 0; sz < 4; sz++)
            for (int lo = 0; lo < 4; lo++)
                for (int inc = 0; inc < 2; inc++)
                    for (int be = 0; be < 2; be++)
                        do_xfer(32'h4000_1000 + 32'(lo), 2'(sz), 1'(inc), 1'(be));

        // R5: wrap at the top of the space
        do_xfer(32'hFFFF_FFFF, 2'b00, 1'b1, 1'b0);
        chk("R5 byte wrap", reg_rdata, 32'h0);
        do_xfer(32'hFFFF_FFFE, 2'b01, 1'b1, 1'b0);
        chk("R5 word wrap", reg_rdata, 32'h0);
        do_xfer(32'hFFFF_FFFC, 2'b10, 1'b1, 1'b1);
        chk("R5 long wrap", reg_rdata, 32'h0);

        // R10: write and completion together
        wr_addr(32'h0000_0100);
        op_size = 2'b10; incr_en = 1'b1; start_req = 1'b1; cyc(); start_req = 1'b0;
        xfer_done = 1'b1; reg_wr = 1'b1; reg_wdata = 32'hABCD_0000;
        cyc(); xfer_done = 1'b0; reg_wr = 1'b0;
        chk("R10 write wins", reg_rdata, 32'hABCD_0000);

        // R9: stop blocks read, write and clear
        wr_addr(32'h0000_0200);
        mod_stop = 1'b1; cyc();
        chk("R9 read zero while stopped", reg_rdata, 32'h0);
        wr_addr(32'hDEAD_BEEF);
        mod_stop = 1'b0; cyc();
        chk("R9 write ignored while stopped", reg_rdata, 32'h0000_0200);
        wr_addr(32'h0000_0201);
        op_size = 2'b01; start_req = 1'b1; cyc(); start_req = 1'b0;
        chk("R6 odd word start", {31'd0, cfg_err}, 32'd1);
        mod_stop = 1'b1; err_clr = 1'b1; cyc(); err_clr = 1'b0; mod_stop = 1'b0; cyc();
        chk("R9 clear ignored while stopped", {31'd0, cfg_err}, 32'd1);
        err_clr = 1'b1; cyc(); err_clr = 1'b0;
        chk("R7 clear after stop lifted", {31'd0, cfg_err}, 32'd0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule